// File: doc/BRIEF.md
# Resumable NMI trap controller

This block decides where a hart goes on trap entry and on return from a resumable non-maskable interrupt, and it owns the state saved for both. It takes an NMI request, a synchronous exception with its cause code, the current PC, the current privilege and virtualization mode, a small CSR access port and a return strobe. It produces a registered redirect: a valid pulse, a target address, and the privilege and virtualization mode to run in next. It also exports the NMI enable bit.

The block has two NMI-context handler addresses. NMIs enter at one of them. A synchronous exception raised while the NMI enable is clear, meaning while the hart is inside the NMI handler, goes to the other. That exception saves its PC and cause in the ordinary machine exception registers and forces the saved previous mode to machine mode. An exception raised while the enable is set goes to the ordinary trap vector. Software in machine mode can set the enable bit but cannot clear it. NMIs that arrive while the enable is clear are held pending, so none are lost.

The CSR port selects a register with `csr_sel`: 0 is NMI PC, 1 is NMI cause, 2 is NMI status, 3 is exception PC, 4 is exception cause and 5 is the machine status register. In the machine status register only the saved-mode field is kept. In the NMI status register, bit 3 is the enable, bits 12:11 are the saved privilege and bit 13 is the saved virtualization bit. Privilege encodings are 0 for user, 1 for supervisor and 3 for machine.

Top module: `rnmi_trap_ctl`

## Requirements
- R1: After reset, `rnmie` is 1, `redirect_valid` is 0, no NMI is pending, and the NMI PC, NMI cause, exception PC, exception cause and saved-mode fields all read 0. The NMI status register therefore reads 0x8.
- R2: An NMI request in a cycle where `rnmie` is 1 produces the following redirect one cycle later:
  - `redirect_valid` is 1 and `redirect_pc` is `NMI_VEC`.
  - The redirect privilege is 3 and the redirect virtualization bit is 0.
  - `rnmie` reads 0.
- R3: A taken NMI saves state as follows:
  - `cur_pc` goes to the NMI PC and `NMI_CAUSE` goes to the NMI cause.
  - `cur_priv` goes to NMI status bits 12:11.
  - `cur_virt` goes to NMI status bit 13.
- R4: An NMI request made while `rnmie` is 0 produces no redirect and stays pending. It is taken, with the R2 redirect, one cycle after `rnmie` becomes 1 again.
- R5: A synchronous exception while `rnmie` is 0 does the following:
  - It writes `cur_pc` to the exception PC and `exc_cause` to the exception cause.
  - It sets the machine status saved-mode field (bits 12:11) to 3.
  - It redirects to `NMI_EXC_VEC` with privilege 3, and `rnmie` stays 0.
- R6: A synchronous exception while `rnmie` is 1 saves the PC and cause in the same way as R5. It then stores `cur_priv` in the machine status saved-mode field and redirects to `TRAP_VEC` with privilege 3.
- R7: When an NMI is taken in the same cycle as a synchronous exception, only the NMI is acted on. The redirect is `NMI_VEC`, and the exception PC, exception cause and machine status are unchanged.
- R8: `mnret` with no exception and no NMI being taken in the same cycle has three effects one cycle later:
  - It redirects to the saved NMI PC.
  - It sets the redirect privilege and virtualization bit from NMI status bits 12:11 and 13.
  - It sets `rnmie` to 1.
- R9: A CSR write in machine mode with `wdata[3]`=1 to the NMI status register sets `rnmie`. A write with `wdata[3]`=0 leaves `rnmie` unchanged, and the other fields of the register take the written values.
- R10: CSR writes made while `cur_priv` is not 3, or while `cur_virt` is 1, change no register.
- R11: NMI status bit 14 and all bits not named in R3 and R9 read 0. Bit 13 reads 0 when `HYP_EN` is 0. In the machine status register, only bits 12:11 can be nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | NMI request |
| exc_valid | input | 1 | Synchronous exception this cycle |
| exc_cause | input | CAUSE_W | Exception cause code |
| cur_pc | input | XLEN | PC of the current instruction |
| cur_priv | input | 2 | Current privilege mode |
| cur_virt | input | 1 | Current virtualization mode |
| mnret | input | 1 | Return-from-NMI strobe |
| csr_we | input | 1 | CSR write enable |
| csr_sel | input | 3 | CSR select |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | XLEN | Redirect target |
| redirect_priv | output | 2 | Privilege after redirect |
| redirect_virt | output | 1 | Virtualization after redirect |
| rnmie | output | 1 | NMI enable |

## Verification
The NMI and the synchronous exception can arrive in the same cycle. The bench raises both together while the enable is set. It judges the outcome by the redirect target and by reading back the exception PC, exception cause and machine status, which must still hold their earlier values. A second overlap is a return made while an NMI is still pending. The bench checks that the return redirect comes first and that the pending NMI follows one cycle later with a fresh saved PC.

// File: rtl/rnmi_trap_ctl.sv
module rnmi_trap_ctl #(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 6,
  parameter bit HYP_EN = 1'b1,
  parameter logic [XLEN-1:0] NMI_VEC = 'h100,
  parameter logic [XLEN-1:0] NMI_EXC_VEC = 'h200,
  parameter logic [XLEN-1:0] TRAP_VEC = 'h300,
  parameter logic [CAUSE_W-1:0] NMI_CAUSE = 'h2A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_req,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [1:0]         cur_priv,
  input  logic               cur_virt,
  input  logic               mnret,
  input  logic               csr_we,
  input  logic [2:0]         csr_sel,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic [1:0]         redirect_priv,
  output logic               redirect_virt,
  output logic               rnmie
);
  localparam int PAD = XLEN - CAUSE_W;
  localparam logic [1:0] PRV_M = 2'b11;

  logic [XLEN-1:0]    nepc, epc;
  logic [CAUSE_W-1:0] ncause, ecause;
  logic [1:0]         n_mpp, m_mpp;
  logic               n_virt, nmi_pend;

  wire take_nmi = rnmie && (nmi_req || nmi_pend);
  wire take_exc = exc_valid && !take_nmi;
  wire take_ret = mnret && !exc_valid && !take_nmi;
  wire in_trap  = take_nmi || take_exc || take_ret;
  wire csr_ok   = csr_we && (cur_priv == PRV_M) && !cur_virt && !in_trap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnmie <= 1'b1;
      nmi_pend <= 1'b0;
      nepc <= '0;
      epc <= '0;
      ncause <= '0;
      ecause <= '0;
      n_mpp <= '0;
      m_mpp <= '0;
      n_virt <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc <= '0;
      redirect_priv <= PRV_M;
      redirect_virt <= 1'b0;
    end else begin
      redirect_valid <= in_trap;
      if (take_nmi) nmi_pend <= 1'b0;
      else if (nmi_req) nmi_pend <= 1'b1;

      if (take_nmi) begin
        rnmie <= 1'b0;
        nepc <= cur_pc;
        ncause <= NMI_CAUSE;
        n_mpp <= cur_priv;
        n_virt <= HYP_EN ? cur_virt : 1'b0;
        redirect_pc <= NMI_VEC;
        redirect_priv <= PRV_M;
        redirect_virt <= 1'b0;
      end else if (take_exc) begin
        epc <= cur_pc;
        ecause <= exc_cause;
        m_mpp <= rnmie ? cur_priv : PRV_M;
        redirect_pc <= rnmie ? TRAP_VEC : NMI_EXC_VEC;
        redirect_priv <= PRV_M;
        redirect_virt <= 1'b0;
      end else if (take_ret) begin
        rnmie <= 1'b1;
        redirect_pc <= nepc;
        redirect_priv <= n_mpp;
        redirect_virt <= n_virt;
      end else if (csr_ok) begin
        case (csr_sel)
          3'd0: nepc <= csr_wdata;
          3'd1: ncause <= csr_wdata[CAUSE_W-1:0];
          3'd2: begin
            if (csr_wdata[3]) rnmie <= 1'b1;
            n_mpp <= csr_wdata[12:11];
            n_virt <= HYP_EN ? csr_wdata[13] : 1'b0;
          end
          3'd3: epc <= csr_wdata;
          3'd4: ecause <= csr_wdata[CAUSE_W-1:0];
          3'd5: m_mpp <= csr_wdata[12:11];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_sel)
      3'd0: csr_rdata = nepc;
      3'd1: csr_rdata = {{PAD{1'b0}}, ncause};
      3'd2: begin
        csr_rdata[3] = rnmie;
        csr_rdata[12:11] = n_mpp;
        csr_rdata[13] = n_virt;
      end
      3'd3: csr_rdata = epc;
      3'd4: csr_rdata = {{PAD{1'b0}}, ecause};
      3'd5: csr_rdata[12:11] = m_mpp;
      default: ;
    endcase
  end
endmodule

module rnmi_trap_ctl_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] NMI_VEC = 'h100,
  parameter logic [XLEN-1:0] NMI_EXC_VEC = 'h200
) (
  input logic            clk,
  input logic            rst_n,
  input logic            nmi_req,
  input logic            exc_valid,
  input logic            mnret,
  input logic            rnmie,
  input logic            pend,
  input logic            rd_valid,
  input logic [XLEN-1:0] rd_pc,
  input logic [1:0]      rd_priv,
  input logic [2:0]      csr_sel,
  input logic [XLEN-1:0] csr_rdata
);
  AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    rnmie && nmi_req |=> rd_valid && rd_pc == NMI_VEC && rd_priv == 2'b11 && !rnmie); // R2
  AST_RNMIE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rnmie) |-> rd_valid && rd_pc == NMI_VEC); // R2
  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rnmie && nmi_req |=> pend); // R4
  AST_EXC_IN_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    !rnmie && exc_valid |=> rd_valid && rd_pc == NMI_EXC_VEC && rd_priv == 2'b11 && !rnmie); // R5
  AST_RET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mnret && !exc_valid && !(rnmie && (nmi_req || pend)) |=> rnmie && rd_valid); // R8
  AST_BIT14_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_sel == 3'd2 |-> csr_rdata[14] == 1'b0); // R11
endmodule

bind rnmi_trap_ctl rnmi_trap_ctl_chk #(.XLEN(XLEN), .NMI_VEC(NMI_VEC), .NMI_EXC_VEC(NMI_EXC_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .exc_valid(exc_valid), .mnret(mnret),
  .rnmie(rnmie), .pend(nmi_pend), .rd_valid(redirect_valid), .rd_pc(redirect_pc),
  .rd_priv(redirect_priv), .csr_sel(csr_sel), .csr_rdata(csr_rdata));

// File: tb/rnmi_trap_ctl_test.sv
module rnmi_trap_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NV = 32'h100, NEV = 32'h200, TV = 32'h300;
  localparam logic [5:0] NC = 6'h2A;

  logic clk = 0, rst_n = 0;
  logic nmi_req = 0, exc_valid = 0, cur_virt = 0, mnret = 0, csr_we = 0;
  logic [5:0] exc_cause = 0;
  logic [31:0] cur_pc = 0, csr_wdata = 0;
  logic [1:0] cur_priv = 2'b11;
  logic [2:0] csr_sel = 0;
  logic [31:0] csr_rdata, redirect_pc;
  logic redirect_valid, redirect_virt, rnmie;
  logic [1:0] redirect_priv;
  int checks = 0, fails = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rnmi_trap_ctl #(.XLEN(32), .CAUSE_W(6), .HYP_EN(1'b1), .NMI_VEC(NV), .NMI_EXC_VEC(NEV),
    .TRAP_VEC(TV), .NMI_CAUSE(NC)) uut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .cur_pc(cur_pc), .cur_priv(cur_priv), .cur_virt(cur_virt), .mnret(mnret), .csr_we(csr_we),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .redirect_priv(redirect_priv),
    .redirect_virt(redirect_virt), .rnmie(rnmie));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    nmi_req = 0; exc_valid = 0; mnret = 0; csr_we = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] s, input logic [31:0] exp);
    csr_sel = s; #1; chk(req, csr_rdata, exp);
  endtask

  task automatic redir(input string req, input logic [31:0] pc, input logic [1:0] p, input logic v);
    chk(req, {29'b0, redirect_valid, 2'b0}, 32'h4);
    chk(req, redirect_pc, pc);
    chk(req, {29'b0, redirect_virt, redirect_priv}, {29'b0, v, p});
  endtask

  function automatic logic [31:0] nst(input logic en, input logic [1:0] p, input logic v);
    return (32'(v) << 13) | (32'(p) << 11) | (32'(en) << 3);
  endfunction

  task automatic nmi_at(input logic [31:0] pc, input logic [1:0] p, input logic v);
    cur_pc = pc; cur_priv = p; cur_virt = v; nmi_req = 1; cyc();
    cur_priv = 2'b11; cur_virt = 0;
  endtask

  task automatic ret();
    cur_priv = 2'b11; cur_virt = 0; mnret = 1; cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] old_epc;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 rnmie", {31'b0, rnmie}, 1);
    chk("R1 valid", {31'b0, redirect_valid}, 0);
    rd("R1", 0, 0); rd("R1", 1, 0); rd("R1", 2, 32'h8); rd("R1", 3, 0); rd("R1", 4, 0); rd("R1", 5, 0);

    for (int i = 0; i < 6; i++) begin
      logic [1:0] p = (i / 2 == 2) ? 2'b11 : 2'(i / 2);
      logic v = (p == 2'b11) ? 1'b0 : 1'(i % 2);
      logic [31:0] pc = 32'h1000 + 32'(i * 16);
      nmi_at(pc, p, v);
      redir("R2", NV, 2'b11, 0);
      chk("R2 rnmie", {31'b0, rnmie}, 0);
      rd("R3 pc", 0, pc); rd("R3 cause", 1, 32'(NC)); rd("R3 status", 2, nst(0, p, v));
      for (int c = 0; c < 3; c++) begin
        cur_pc = pc + 4 + 32'(c); exc_valid = 1; exc_cause = 6'(c * 5 + i); cyc();
        redir("R5", NEV, 2'b11, 0);
        chk("R5 rnmie", {31'b0, rnmie}, 0);
        rd("R5 epc", 3, pc + 4 + 32'(c)); rd("R5 cause", 4, 32'(c * 5 + i)); rd("R5 mpp", 5, 32'h1800);
      end
      csr_sel = 2; csr_wdata = nst(0, p, v); csr_we = 1; cyc();
      chk("R9 write0", {31'b0, rnmie}, 0);
      ret();
      redir("R8", pc, p, v);
      chk("R8 rnmie", {31'b0, rnmie}, 1);
    end

    for (int p = 0; p < 2; p++) begin
      cur_pc = 32'h2000 + 32'(p); cur_priv = 2'(p); exc_valid = 1; exc_cause = 6'(9 + p); cyc();
      redir("R6", TV, 2'b11, 0);
      chk("R6 rnmie", {31'b0, rnmie}, 1);
      rd("R6 epc", 3, 32'h2000 + 32'(p)); rd("R6 cause", 4, 32'(9 + p)); rd("R6 mpp", 5, 32'(p) << 11);
    end
    cur_priv = 2'b11;

    old_epc = 32'h2001;
    cur_pc = 32'h3000; cur_priv = 2'b01; nmi_req = 1; exc_valid = 1; exc_cause = 6'h3F; cyc();
    redir("R7", NV, 2'b11, 0);
    rd("R7 epc", 3, old_epc); rd("R7 cause", 4, 32'd10); rd("R7 mpp", 5, 32'h0800);
    rd("R7 nepc", 0, 32'h3000);

    cur_pc = 32'h3100; nmi_req = 1; cyc();
    chk("R4 no redirect", {31'b0, redirect_valid}, 0);
    rd("R4 nepc kept", 0, 32'h3000);
    cur_pc = 32'h3200; ret();
    redir("R4 ret first", 32'h3000, 2'b01, 0);
    cyc();
    redir("R4 pending taken", NV, 2'b11, 0);
    chk("R4 rnmie", {31'b0, rnmie}, 0);
    rd("R4 nepc", 0, 32'h3200);

    cur_priv = 2'b01; csr_sel = 2; csr_wdata = 32'hFFFF_FFFF; csr_we = 1; cyc();
    chk("R10 rnmie", {31'b0, rnmie}, 0);
    cur_priv = 2'b11; cur_virt = 1; csr_sel = 3; csr_wdata = 32'h5555; csr_we = 1; cyc();
    cur_virt = 0;
    rd("R10 epc", 3, old_epc);
    rd("R10 status", 2, nst(0, 2'b11, 0));

    csr_sel = 2; csr_wdata = 32'hFFFF_FFFF; csr_we = 1; cyc();
    chk("R9 set", {31'b0, rnmie}, 1);
    chk("R9 no redirect", {31'b0, redirect_valid}, 0);
    rd("R11 status", 2, nst(1, 2'b11, 1));
    csr_sel = 5; csr_wdata = 32'hFFFF_FFFF; csr_we = 1; cyc();
    rd("R11 mstatus", 5, 32'h1800);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule